// File: doc/BRIEF.md
# Timer with compare match

An 8-bit timer/counter with one output-compare channel, intended to sit on a simple register bus inside a larger chip. A 3-bit source select chooses what advances the counter: nothing (stopped), every system clock, one of four fixed prescaler taps, or one edge polarity of an external input pin. Software reads and writes the counter, the compare value, the source select and an interrupt control register through a single-cycle write port and a combinational read port.

Whenever the counter advances while it holds the compare value, a compare flag is set. An interrupt request goes high while the flag, the local compare enable and a chip-wide interrupt enable are all high. The flag is cleared by writing 1 to it or by an interrupt acknowledge pulse. A software write to the counter suppresses the compare match on the very next timer tick, so that loading the counter with the compare value does not produce a spurious match.

Two small state machines carry the control. The external edge detector has states EDGE_LOW and EDGE_HIGH. It moves EDGE_LOW to EDGE_HIGH when the synchronized pin reads 1, producing a rising pulse, and EDGE_HIGH to EDGE_LOW when it reads 0, producing a falling pulse. The compare flag has states FLAG_IDLE and FLAG_PEND. It moves FLAG_IDLE to FLAG_PEND on a match, and FLAG_PEND to FLAG_IDLE on a clear or acknowledge that is not coincident with a new match.

Top module: `timer8_cmp`

## Requirements
- R1: After reset the counter, the compare value, the source select, the compare enable and the compare flag all read 0, and the interrupt request is low.
- R2: With source select 000 the counter holds its value; only a bus write changes it.
- R3: With source select 001 the counter advances by one on every clock and wraps from 255 to 0.
- R4: Source selects 010, 011, 100 and 101 advance the counter once every 8, 64, 256 and 1024 clocks respectively. Each advance happens on the clock edge at which a free-running 10-bit divider, cleared by reset and incremented every clock, holds a value whose low 3, 6, 8 or 10 bits are all ones.
- R5: Source select 110 counts falling edges and 111 counts rising edges of the external pin. The pin passes through two synchronizing flops, each edge gives exactly one count, the opposite edge gives none, and the pin is sampled whatever drives it.
- R6: Register map, with the address on bus_addr: 0 is the counter, 1 is the compare value, 2 holds the source select in bits 2:0, and 3 holds the compare enable in bit 0 and the compare flag in bit 1. Unused bits read 0. A write to the counter takes precedence over a tick in the same cycle.
- R7: A tick that occurs while the counter equals the compare value sets the compare flag.
- R8: The first tick after a software write to the counter never sets the compare flag, even if the counter equals the compare value.
- R9: While the counter is stopped, equality of counter and compare value does not set the flag.
- R10: Writing 1 to bit 1 of address 3, or pulsing irq_ack, clears the flag. Writing 0 to that bit leaves it unchanged, and a match in the same cycle as a clear wins.
- R11: irq is high exactly when the compare flag, the compare enable and global_ie are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_pin | input | 1 | External count input, asynchronous |
| global_ie | input | 1 | Chip-wide interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench measures the counter across windows in each prescaled mode, against a divider phase it tracks itself. A design that restarted the divider on a select change, or that counted on the wrong tap bit, ends a window with a count off by one or more. It loads the counter with the compare value and checks that no flag follows, then loads it one below and checks that a flag does; a design without the suppression, or one that suppressed the wrong tick, fails one of the two. It also holds the counter equal to the compare value while stopped, feeds opposite-polarity pin edges in each external mode, and writes 0 to the flag bit. A design that matched on every clock, counted both edges, or cleared on any write to address 3 is caught by these.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_SYS      = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
    localparam logic [ADDR_W-1:0] A_SEL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_INT   = 2'd3;

    localparam int NUM_TAPS = 4;
    localparam int BIT_IE   = 0;
    localparam int BIT_FLAG = 1;

endpackage

// File: rtl/timer8_prescaler.sv
module timer8_prescaler #(
    parameter int PRE_W    = 10,
    parameter int NUM_TAPS = 4,
    parameter int TAP_LOG2 [NUM_TAPS] = '{3, 6, 8, 10}
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tap_en
);

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Each tap fires for one cycle when its low bits are all ones.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int LB = TAP_LOG2[t];
        assign tap_en[t] = &pre_cnt[LB-1:0];
    end

endmodule

// File: rtl/timer8_edge.sv
module timer8_edge
    import timer8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_p,
    output logic fall_p
);

    logic        sync1_q;
    logic        sync2_q;
    edge_state_e state_q;
    edge_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_async;
            sync2_q <= sync1_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (sync2_q)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!sync2_q) state_d = EDGE_LOW;
        endcase
    end

    // Outputs: one pulse per transition
    always_comb begin
        rise_p = 1'b0;
        fall_p = 1'b0;
        unique case (state_q)
            EDGE_LOW:  rise_p = sync2_q;
            EDGE_HIGH: fall_p = !sync2_q;
        endcase
    end

endmodule

// File: rtl/timer8_flag.sv
module timer8_flag
    import timer8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i)           state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        pend_o = 1'b0;
        unique case (state_q)
            FLAG_IDLE: pend_o = 1'b0;
            FLAG_PEND: pend_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/timer8_cmp.sv
module timer8_cmp
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_pin,
    input  logic              global_ie,
    input  logic              irq_ack,
    output logic              irq
);

    localparam int TAP8    = 0;
    localparam int TAP64   = 1;
    localparam int TAP256  = 2;
    localparam int TAP1024 = 3;

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cmp_q;
    clk_sel_e            sel_q;
    logic                ie_q;
    logic                blk_q;
    logic [NUM_TAPS-1:0] tap_en;
    logic                ext_rise;
    logic                ext_fall;
    logic                tick;
    logic                match;
    logic                flag;
    logic                flag_clr;
    logic                wr_cnt;

    timer8_prescaler #(
        .PRE_W    (PRE_W),
        .NUM_TAPS (NUM_TAPS),
        .TAP_LOG2 ('{3, 6, 8, 10})
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_en (tap_en)
    );

    timer8_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .rise_p    (ext_rise),
        .fall_p    (ext_fall)
    );

    // Tick source selection
    always_comb begin
        tick = 1'b0;
        unique case (sel_q)
            CS_STOP:     tick = 1'b0;
            CS_SYS:      tick = 1'b1;
            CS_DIV8:     tick = tap_en[TAP8];
            CS_DIV64:    tick = tap_en[TAP64];
            CS_DIV256:   tick = tap_en[TAP256];
            CS_DIV1024:  tick = tap_en[TAP1024];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
        endcase
    end

    assign wr_cnt   = bus_wr && (bus_addr == A_COUNT);
    assign match    = tick && !blk_q && (cnt_q == cmp_q);
    assign flag_clr = irq_ack || (bus_wr && (bus_addr == A_INT) && bus_wdata[BIT_FLAG]);

    // Counter and its write-suppression marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else if (wr_cnt) begin
            cnt_q <= bus_wdata;
            blk_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            blk_q <= 1'b0;
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            sel_q <= CS_STOP;
            ie_q  <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CMP:   cmp_q <= bus_wdata;
                A_SEL:   sel_q <= clk_sel_e'(bus_wdata[2:0]);
                A_INT:   ie_q  <= bus_wdata[BIT_IE];
                default: ;
            endcase
        end
    end

    timer8_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (match),
        .clr_i  (flag_clr),
        .pend_o (flag)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_COUNT: bus_rdata = cnt_q;
            A_CMP:   bus_rdata = cmp_q;
            A_SEL:   bus_rdata[2:0] = sel_q;
            A_INT: begin
                bus_rdata[BIT_IE]   = ie_q;
                bus_rdata[BIT_FLAG] = flag;
            end
        endcase
    end

    assign irq = flag && ie_q && global_ie;

endmodule

// File: rtl/timer8_cmp_chk.sv
module timer8_cmp_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel,
    input logic             tick,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             blk,
    input logic             match,
    input logic             flag,
    input logic             ie,
    input logic             gie,
    input logic             ack,
    input logic             irq
);

    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b000 && !wr_cnt) |=> $stable(cnt));

    assert_sys_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b001 && !wr_cnt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !blk && cnt == cmp) |=> flag);

    assert_blocked_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && tick && !flag) |=> !flag);

    assert_stopped_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b000 && !flag) |=> !flag);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && flag && !match) |=> !flag);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie && gie));

endmodule

bind timer8_cmp timer8_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel_q),
    .tick   (tick),
    .wr_cnt (wr_cnt),
    .cnt    (cnt_q),
    .cmp    (cmp_q),
    .blk    (blk_q),
    .match  (match),
    .flag   (flag),
    .ie     (ie_q),
    .gie    (global_ie),
    .ack    (irq_ack),
    .irq    (irq)
);

// File: tb/timer8_cmp_bench.sv
`timescale 1ns/1ps
module timer8_cmp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       global_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    int ph = 0;

    always #5 clk = ~clk;

    // Divider phase as the requirement defines it: cleared by reset, +1 per clock.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 0;
        else        ph <= ph + 1;
    end

    timer8_cmp u_timer8_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_pin   (ext_pin),
        .global_ie (global_ie),
        .irq_ack   (irq_ack),
        .irq       (irq)
    );

    // {sel, start value, cycles}
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 8'd5,   16'd20},
        {3'd1, 8'd10,  16'd30},
        {3'd1, 8'd250, 16'd10},
        {3'd2, 8'd0,   16'd50},
        {3'd3, 8'd7,   16'd200},
        {3'd4, 8'd3,   16'd600},
        {3'd5, 8'd0,   16'd2100},
        {3'd2, 8'd255, 16'd9}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int ticks_in(input int sel, input int ph0, input int n);
        int d;
        int c;
        c = 0;
        case (sel)
            1: d = 1;
            2: d = 8;
            3: d = 64;
            4: d = 256;
            5: d = 1024;
            default: d = 0;
        endcase
        if (d == 0) return 0;
        for (int k = ph0; k < ph0 + n; k++) if ((k % d) == d - 1) c++;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int ph0;
        int exp_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 counter", v, 0);
        rd(2'd1, v); check("R1 compare", v, 0);
        rd(2'd2, v); check("R1 select", v, 0);
        rd(2'd3, v); check("R1 int reg", v, 0);
        check("R1 irq", int'(irq), 0);

        // R2/R3/R4 vector table; compare parked far away
        wr(2'd1, 8'd128);
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  s;
            logic [7:0]  st;
            logic [15:0] n;
            {s, st, n} = VEC[i];
            wr(2'd2, {5'd0, s});
            wr(2'd0, st);
            ph0 = ph;
            repeat (int'(n)) @(negedge clk);
            exp_cnt = (int'(st) + ticks_in(int'(s), ph0, int'(n))) % 256;
            rd(2'd0, v);
            check($sformatf("R2 R3 R4 vector %0d sel=%0d", i, s), v, exp_cnt);
        end

        // R5 rising-edge mode
        wr(2'd2, 8'd7);
        wr(2'd0, 8'd0);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R5 rise counts", v, 1);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R5 fall ignored in rise mode", v, 1);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R5 second rise", v, 2);

        // R5 falling-edge mode
        wr(2'd2, 8'd6);
        wr(2'd0, 8'd0);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R5 fall counts", v, 1);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R5 rise ignored in fall mode", v, 1);

        // R6 register read-back, unused bits zero
        wr(2'd2, 8'hF8);
        rd(2'd2, v); check("R6 select unused bits", v, 0);
        wr(2'd3, 8'hFD);
        rd(2'd3, v); check("R6 int reg ie only", v, 1);
        wr(2'd3, 8'h00);

        // R7 match: counter one below compare
        wr(2'd1, 8'd6);
        wr(2'd0, 8'd5);
        wr(2'd3, 8'd1);
        global_ie = 1'b1;
        wr(2'd2, 8'd1);
        @(negedge clk);
        rd(2'd3, v); check("R7 no flag before match", v, 1);
        @(negedge clk);
        rd(2'd3, v); check("R7 flag set on match", v, 3);
        wr(2'd2, 8'd0);
        check("R11 irq all enables", int'(irq), 1);
        global_ie = 1'b0; #1;
        check("R11 irq global off", int'(irq), 0);
        global_ie = 1'b1;
        wr(2'd3, 8'd0);
        check("R11 irq local off", int'(irq), 0);

        // R10 clearing
        wr(2'd3, 8'd1);
        rd(2'd3, v); check("R10 write 0 keeps flag", v, 3);
        wr(2'd3, 8'd3);
        rd(2'd3, v); check("R10 write 1 clears", v, 1);
        check("R10 irq dropped", int'(irq), 0);
        wr(2'd0, 8'd5);
        wr(2'd2, 8'd1);
        repeat (2) @(negedge clk);
        wr(2'd2, 8'd0);
        rd(2'd3, v); check("R10 flag set again", v, 3);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        rd(2'd3, v); check("R10 ack clears", v, 1);

        // R9 stopped while equal
        wr(2'd0, 8'd6);
        repeat (10) @(negedge clk);
        rd(2'd3, v); check("R9 stopped equal no flag", v, 1);

        // R8 write equal to compare, then run
        wr(2'd1, 8'd20);
        wr(2'd0, 8'd20);
        wr(2'd2, 8'd1);
        repeat (5) @(negedge clk);
        wr(2'd2, 8'd0);
        rd(2'd3, v); check("R8 blocked first tick", v, 1);
        rd(2'd0, v); check("R8 counter still advanced", v, 27);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule